// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block gives software control over 128 general-purpose pins, arranged as four banks of 32. Each bank has its own register group: synchronised input level, direction, write-one-to-set and write-one-to-clear ports onto the output latch, rising and falling edge enables, and a sticky edge status word. A separate region holds a 2-bit function-select code for every pin. A derived per-bank "busy" word reports which pins cannot be used as plain GPIO right now.

Accesses use a single-cycle 32-bit register bus with a byte address. Writes take effect at the clock edge on which `bus_we` is high. Read data is combinational from the address. Pin inputs pass through a two-flop synchroniser before the block reads their level or detects edges. Every status bit feeds one combined interrupt line.

Four pins, 86 through 89, follow an inverted convention. A direction bit of 0 makes them drive, and function code 1 selects plain GPIO for them.

Top module: `gpio_banked`

## Requirements
- R1: The bank register groups start at byte offsets 0x000, 0x004, 0x008 for banks 0..2 and at 0x100 for bank 3. Within a group the offsets are: level +0x00, direction +0x0C, set +0x18, clear +0x24, rising enable +0x30, falling enable +0x3C, status +0x48. A write to one bank's register leaves every other bank unchanged. Bank b holds pins 32b..32b+31, and bit i is pin 32b+i.
- R2: A write to the set register raises each output latch bit whose write bit is 1. A write to the clear register lowers each such bit. Zero bits leave the latch alone. Reads of either register return the latch, and the latch drives `pin_out`.
- R3: For ordinary pins, a direction bit of 1 makes the pin drive (`pin_oe`=1) and 0 makes it an input.
- R4: For pins 86..89 (bank 2 bits 22..25), a direction bit of 0 makes the pin drive and 1 makes it an input. For these pins, function code 1 is plain GPIO. For every other pin, code 0 is plain GPIO.
- R5: Function codes are 2 bits per pin, 16 pins per word. The word for pin p sits at 0x054 + 4*(p/16), and its field starts at bit 2*(p mod 16). The codes appear on `pin_af[2p+1:2p]` and can be read back.
- R6: The read-only busy word of bank b sits at 0x180 + 4*b. Its bit i is 1 when the pin's function code is not that pin's GPIO code, or when the pin is driving.
- R7: The level register shows a pin's input after exactly two rising clock edges (two-flop synchroniser). Writes to the level register are ignored.
- R8: A status bit sets when its pin shows a change in synchronised level in a direction that is enabled (0→1 with rising enable, 1→0 with falling enable). A change in a direction that is not enabled leaves the bit clear.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it alone. If an enabled edge arrives in the same cycle as the clear, the bit stays set.
- R10: `irq` is high exactly when at least one status bit in any bank is set.
- R11: Addresses that map to no register read as zero, and writes to them change nothing.
- R12: After reset, all output latches are 0 and no pin drives: direction reads 0 for ordinary pins and 1 for pins 86..89. Enables and status are 0, and every pin's function code is its GPIO code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 128 | Raw pin inputs |
| pin_out | output | 128 | Output latch values |
| pin_oe | output | 128 | Output enables (1 = pin drives) |
| pin_af | output | 256 | Function-select code, 2 bits per pin |
| irq | output | 1 | OR of all edge status bits |

## Verification
The bench goes after the irregular address map. It writes bank 3 at 0x100 and the low banks at their interleaved offsets. A decoder that placed bank 3 at 0x00C would show its outputs moving on a bank 0 access. Pins 86..89 get their own checks: a design that did not flip their direction or their GPIO code would make them drive or report them busy straight after reset. A synchroniser of the wrong depth shows up, because the level is sampled one edge too early and then exactly on time. The bench also times a status clear into the very cycle of a falling edge on the same pin. A design that gives priority to the clear would lose the event and drop `irq`.

// File: rtl/gpiox_pkg.sv
package gpiox_pkg;

    localparam int unsigned BANK_W      = 32;
    localparam int unsigned NUM_BANKS   = 4;
    localparam int unsigned NUM_PINS    = BANK_W * NUM_BANKS;
    localparam int unsigned ADDR_W      = 9;
    localparam int unsigned AF_W        = 2;
    localparam int unsigned AF_PER_WORD = BANK_W / AF_W;
    localparam int unsigned AF_WORDS    = NUM_PINS / AF_PER_WORD;
    localparam int unsigned INV_LO      = 86;
    localparam int unsigned INV_HI      = 89;

    localparam logic [ADDR_W-1:0] OFF_LVL   = 9'h000;
    localparam logic [ADDR_W-1:0] OFF_DIR   = 9'h00C;
    localparam logic [ADDR_W-1:0] OFF_SET   = 9'h018;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 9'h024;
    localparam logic [ADDR_W-1:0] OFF_REN   = 9'h030;
    localparam logic [ADDR_W-1:0] OFF_FEN   = 9'h03C;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 9'h048;
    localparam logic [ADDR_W-1:0] AF_BASE   = 9'h054;
    localparam logic [ADDR_W-1:0] BUSY_BASE = 9'h180;
    localparam logic [ADDR_W-1:0] HIGH_BASE = 9'h100;

    typedef struct packed {
        logic [BANK_W-1:0] out_lat;
        logic [BANK_W-1:0] dir;
        logic [BANK_W-1:0] rise_en;
        logic [BANK_W-1:0] fall_en;
        logic [BANK_W-1:0] stat;
        logic [BANK_W-1:0] prev;
    } bank_state_t;

    // Low banks interleave at 4-byte stride; the last bank is relocated.
    function automatic logic [ADDR_W-1:0] bank_base(input int unsigned b);
        return (b < NUM_BANKS - 1) ? ADDR_W'(b * 4) : HIGH_BASE;
    endfunction

    function automatic logic [BANK_W-1:0] inv_mask(input int unsigned b);
        logic [BANK_W-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < BANK_W; i++) begin
            if ((b * BANK_W + i) >= INV_LO && (b * BANK_W + i) <= INV_HI) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [BANK_W-1:0] af_word_reset(input int unsigned k);
        logic [BANK_W-1:0] w;
        w = '0;
        for (int unsigned j = 0; j < AF_PER_WORD; j++) begin
            if ((k * AF_PER_WORD + j) >= INV_LO && (k * AF_PER_WORD + j) <= INV_HI)
                w[j*AF_W] = 1'b1;
        end
        return w;
    endfunction

endpackage

// File: rtl/gpiox_sync.sv
module gpiox_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_d, meta_q;
    logic [W-1:0] stab_d, stab_q;

    always_comb begin
        meta_d = raw_i;
        stab_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/gpiox_altfn.sv
module gpiox_altfn
    import gpiox_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [BANK_W-1:0]        wdata_i,
    output logic [NUM_PINS*AF_W-1:0] af_o,
    output logic [BANK_W-1:0]        rdata_o
);
    logic [BANK_W-1:0] word_d [AF_WORDS];
    logic [BANK_W-1:0] word_q [AF_WORDS];

    always_comb begin
        rdata_o = '0;
        for (int unsigned k = 0; k < AF_WORDS; k++) begin
            word_d[k] = word_q[k];
            if (addr_i == AF_BASE + ADDR_W'(k * 4)) begin
                rdata_o = word_q[k];
                if (we_i) word_d[k] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int unsigned k = 0; k < AF_WORDS; k++) word_q[k] <= af_word_reset(k);
        end else begin
            for (int unsigned k = 0; k < AF_WORDS; k++) word_q[k] <= word_d[k];
        end
    end

    for (genvar k = 0; k < AF_WORDS; k++) begin : g_af_out
        assign af_o[k*BANK_W +: BANK_W] = word_q[k];
    end
endmodule

// File: rtl/gpiox_bank.sv
module gpiox_bank
    import gpiox_pkg::*;
#(
    parameter int unsigned BANK_IDX = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [BANK_W-1:0]      wdata_i,
    input  logic [BANK_W-1:0]      pin_i,
    input  logic [BANK_W*AF_W-1:0] af_i,
    output logic [BANK_W-1:0]      out_o,
    output logic [BANK_W-1:0]      oe_o,
    output logic [BANK_W-1:0]      stat_o,
    output logic [BANK_W-1:0]      rdata_o
);
    localparam logic [ADDR_W-1:0] BASE   = bank_base(BANK_IDX);
    localparam logic [ADDR_W-1:0] A_LVL  = BASE + OFF_LVL;
    localparam logic [ADDR_W-1:0] A_DIR  = BASE + OFF_DIR;
    localparam logic [ADDR_W-1:0] A_SET  = BASE + OFF_SET;
    localparam logic [ADDR_W-1:0] A_CLR  = BASE + OFF_CLR;
    localparam logic [ADDR_W-1:0] A_REN  = BASE + OFF_REN;
    localparam logic [ADDR_W-1:0] A_FEN  = BASE + OFF_FEN;
    localparam logic [ADDR_W-1:0] A_STAT = BASE + OFF_STAT;
    localparam logic [ADDR_W-1:0] A_BUSY = BUSY_BASE + ADDR_W'(BANK_IDX * 4);
    localparam logic [BANK_W-1:0] INV    = inv_mask(BANK_IDX);

    localparam bank_state_t RST = '{
        out_lat: '0, dir: INV, rise_en: '0, fall_en: '0, stat: '0, prev: '0
    };

    logic [BANK_W-1:0] lvl;
    logic [BANK_W-1:0] busy;
    bank_state_t       st_d, st_q;

    gpiox_sync #(.W(BANK_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_i),
        .sync_o (lvl)
    );

    always_comb begin
        logic [BANK_W-1:0] clr_mask;
        logic [BANK_W-1:0] hit_edge;
        st_d     = st_q;
        clr_mask = '0;
        if (we_i) begin
            unique case (addr_i)
                A_DIR:   st_d.dir     = wdata_i;
                A_SET:   st_d.out_lat = st_q.out_lat | wdata_i;
                A_CLR:   st_d.out_lat = st_q.out_lat & ~wdata_i;
                A_REN:   st_d.rise_en = wdata_i;
                A_FEN:   st_d.fall_en = wdata_i;
                A_STAT:  clr_mask     = wdata_i;
                default: ;
            endcase
        end
        hit_edge  = (lvl & ~st_q.prev & st_q.rise_en) | (~lvl & st_q.prev & st_q.fall_en);
        // A fresh edge outranks a simultaneous clear.
        st_d.stat = (st_q.stat & ~clr_mask) | hit_edge;
        st_d.prev = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < BANK_W; i++) begin : g_busy
        localparam logic [AF_W-1:0] GPIO_CODE = INV[i] ? 2'b01 : 2'b00;
        assign busy[i] = (af_i[i*AF_W +: AF_W] != GPIO_CODE) || oe_o[i];
    end

    always_comb begin
        unique case (addr_i)
            A_LVL:   rdata_o = lvl;
            A_DIR:   rdata_o = st_q.dir;
            A_SET:   rdata_o = st_q.out_lat;
            A_CLR:   rdata_o = st_q.out_lat;
            A_REN:   rdata_o = st_q.rise_en;
            A_FEN:   rdata_o = st_q.fall_en;
            A_STAT:  rdata_o = st_q.stat;
            A_BUSY:  rdata_o = busy;
            default: rdata_o = '0;
        endcase
    end

    assign out_o  = st_q.out_lat;
    assign oe_o   = st_q.dir ^ INV;
    assign stat_o = st_q.stat;
endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
    import gpiox_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [BANK_W-1:0]        bus_wdata,
    output logic [BANK_W-1:0]        bus_rdata,
    input  logic [NUM_PINS-1:0]      pin_in,
    output logic [NUM_PINS-1:0]      pin_out,
    output logic [NUM_PINS-1:0]      pin_oe,
    output logic [NUM_PINS*AF_W-1:0] pin_af,
    output logic                     irq
);
    logic [BANK_W-1:0]   bank_rd [NUM_BANKS];
    logic [BANK_W-1:0]   af_rd;
    logic [NUM_PINS-1:0] stat_all;

    gpiox_altfn u_altfn (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_we),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .af_o    (pin_af),
        .rdata_o (af_rd)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpiox_bank #(.BANK_IDX(b)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (bus_we),
            .addr_i  (bus_addr),
            .wdata_i (bus_wdata),
            .pin_i   (pin_in[b*BANK_W +: BANK_W]),
            .af_i    (pin_af[b*BANK_W*AF_W +: BANK_W*AF_W]),
            .out_o   (pin_out[b*BANK_W +: BANK_W]),
            .oe_o    (pin_oe[b*BANK_W +: BANK_W]),
            .stat_o  (stat_all[b*BANK_W +: BANK_W]),
            .rdata_o (bank_rd[b])
        );
    end

    // Every decoder returns zero when not addressed, so OR-merge is exact.
    always_comb begin
        bus_rdata = af_rd;
        for (int unsigned b = 0; b < NUM_BANKS; b++) bus_rdata = bus_rdata | bank_rd[b];
    end

    assign irq = |stat_all;
endmodule

// File: rtl/gpio_banked_chk.sv
module gpio_banked_chk
    import gpiox_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     we,
    input logic [ADDR_W-1:0]        addr,
    input logic [BANK_W-1:0]        wdata,
    input logic [NUM_PINS-1:0]      pin_out,
    input logic [NUM_PINS-1:0]      pin_oe,
    input logic [NUM_PINS*AF_W-1:0] pin_af,
    input logic [NUM_PINS-1:0]      stat
);
    logic stat_write;
    assign stat_write = we && (addr == 9'h048 || addr == 9'h04C ||
                               addr == 9'h050 || addr == 9'h148);

    a_r2_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 9'h018) |=> ((pin_out[31:0] & $past(wdata)) == $past(wdata)));

    a_r2_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 9'h024) |=> ((pin_out[31:0] & $past(wdata)) == '0));

    a_r3_dir_drives_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 9'h00C) |=> (pin_oe[31:0] == $past(wdata)));

    a_r4_inverted_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 9'h014) |=> (pin_oe[89:86] == ~$past(wdata[25:22])));

    a_r5_af_word0: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 9'h054) |=> (pin_af[31:0] == $past(wdata)));

    a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_write |=> ((stat & $past(stat)) == $past(stat)));

    a_r11_unmapped_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 9'h074) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_af)));
endmodule

bind gpio_banked gpio_banked_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .pin_af  (pin_af),
    .stat    (stat_all)
);

// File: tb/test_gpio_banked.sv
module test_gpio_banked;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [8:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] pin_in = '0;
    logic [127:0] pin_out, pin_oe;
    logic [255:0] pin_af;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [127:0] act;
        logic [127:0] exp;
        string        tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    gpio_banked i_gpio_banked (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_af(pin_af), .irq(irq)
    );

    // Monitor: drains the scoreboard away from clock edges.
    initial begin
        forever begin
            @(negedge clk);
            #7;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (it.act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", it.tag, it.act, it.exp);
                end
            end
        end
    end

    task automatic push(input logic [127:0] act, input logic [127:0] exp, input string tag);
        item_t it;
        it.act = act; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // All tasks are entered just after a falling edge.
    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [8:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #5;
        push({96'd0, bus_rdata}, {96'd0, exp}, tag);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [127:0] out_snap, oe_snap;
        logic [255:0] af_snap;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R12 reset state
        push(pin_out, '0, "R12 pin_out after reset");
        push(pin_oe, '0, "R12 pin_oe after reset");
        push({127'd0, irq}, '0, "R12 irq after reset");
        push({120'd0, pin_af[179:172]}, {120'd0, 8'h55}, "R12 R4 inverted pins GPIO code 1");
        rd_chk(9'h00C, 32'h0, "R12 bank0 direction");
        rd_chk(9'h014, 32'h03C00000, "R12 R4 bank2 direction inverted");
        rd_chk(9'h068, 32'h00055000, "R12 R5 function word 5");
        rd_chk(9'h188, 32'h0, "R12 R6 busy bank2");

        // R2 set/clear, R1 bank3 relocation
        wr(9'h018, 32'h000000F0);
        wr(9'h024, 32'h00000030);
        rd_chk(9'h018, 32'h000000C0, "R2 set reg reads latch");
        rd_chk(9'h024, 32'h000000C0, "R2 clear reg reads latch");
        push({96'd0, pin_out[31:0]}, {96'd0, 32'hC0}, "R2 pin_out bank0");
        wr(9'h118, 32'h00000001);
        push(pin_out, {32'h1, 64'd0, 32'hC0}, "R1 bank3 set at 0x118");

        // R3 direction, R1 isolation, R6 busy
        wr(9'h10C, 32'hFFFF0000);
        push({96'd0, pin_oe[127:96]}, {96'd0, 32'hFFFF0000}, "R3 bank3 oe");
        rd_chk(9'h18C, 32'hFFFF0000, "R6 busy bank3 follows driving");
        wr(9'h00C, 32'h0000000F);
        push(pin_oe, {32'hFFFF0000, 64'd0, 32'hF}, "R1 R3 bank0 dir leaves bank3");

        // R4 inverted pins
        wr(9'h014, 32'h03800000);
        push({96'd0, pin_oe[95:64]}, {96'd0, 32'h00400000}, "R4 pin86 drives on dir 0");
        rd_chk(9'h188, 32'h00400000, "R4 R6 busy pin86");
        wr(9'h068, 32'h00051000);
        rd_chk(9'h188, 32'h00C00000, "R4 R6 pin87 code 0 busy");
        push({126'd0, pin_af[175:174]}, '0, "R5 pin87 field");

        // R5 function fields, R6 busy from code
        wr(9'h054, 32'h00000800);
        push({126'd0, pin_af[11:10]}, {126'd0, 2'b10}, "R5 pin5 field");
        rd_chk(9'h054, 32'h00000800, "R5 word0 readback");
        rd_chk(9'h180, 32'h0000002F, "R6 busy bank0");
        wr(9'h070, 32'hC0000000);
        push({126'd0, pin_af[255:254]}, {126'd0, 2'b11}, "R5 pin127 field");

        // R7 synchroniser depth
        pin_in[100] = 1'b1;
        idle(1);
        rd_chk(9'h100, 32'h0, "R7 level not yet after one edge");
        rd_chk(9'h100, 32'h00000010, "R7 level after two edges");
        wr(9'h100, 32'hFFFFFFFF);
        rd_chk(9'h100, 32'h00000010, "R7 level write ignored");
        pin_in[100] = 1'b0;
        idle(4);

        // R8 rising only, R10 irq
        wr(9'h034, 32'h00000008);
        pin_in[35] = 1'b1;
        idle(4);
        rd_chk(9'h04C, 32'h00000008, "R8 rising edge pin35");
        push({127'd0, irq}, {127'd0, 1'b1}, "R10 irq on status");
        wr(9'h04C, 32'h00000000);
        rd_chk(9'h04C, 32'h00000008, "R9 zero write keeps status");
        wr(9'h04C, 32'h00000008);
        pin_in[35] = 1'b0;
        idle(4);
        rd_chk(9'h04C, 32'h0, "R8 R9 falling ignored, cleared");
        push({127'd0, irq}, '0, "R10 irq low when clear");

        // R8 falling only on bank3
        wr(9'h13C, 32'h00000001);
        pin_in[96] = 1'b1;
        idle(4);
        rd_chk(9'h148, 32'h0, "R8 rising ignored pin96");
        pin_in[96] = 1'b0;
        idle(4);
        rd_chk(9'h148, 32'h00000001, "R8 falling edge pin96");
        push({127'd0, irq}, {127'd0, 1'b1}, "R10 irq from bank3");
        wr(9'h148, 32'h00000001);
        push({127'd0, irq}, '0, "R9 R10 bank3 cleared");

        // R9 edge in the same cycle as clear
        wr(9'h034, 32'h00000100);
        wr(9'h040, 32'h00000100);
        pin_in[40] = 1'b1;
        idle(4);
        rd_chk(9'h04C, 32'h00000100, "R8 pin40 rising");
        pin_in[40] = 1'b0;
        idle(2);
        wr(9'h04C, 32'h00000100);
        rd_chk(9'h04C, 32'h00000100, "R9 edge wins over clear");
        wr(9'h04C, 32'h00000100);
        rd_chk(9'h04C, 32'h0, "R9 later clear");

        // R11 unmapped
        out_snap = pin_out; oe_snap = pin_oe; af_snap = pin_af;
        wr(9'h074, 32'hFFFFFFFF);
        wr(9'h1F0, 32'hFFFFFFFF);
        wr(9'h019, 32'hFFFFFFFF);
        rd_chk(9'h074, 32'h0, "R11 unmapped 0x074 reads zero");
        rd_chk(9'h1F0, 32'h0, "R11 unmapped 0x1F0 reads zero");
        push(pin_out, out_snap, "R11 pin_out unchanged");
        push(pin_oe, oe_snap, "R11 pin_oe unchanged");
        push(pin_af[127:0], af_snap[127:0], "R11 pin_af low unchanged");
        push(pin_af[255:128], af_snap[255:128], "R11 pin_af high unchanged");

        idle(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired before the test ended");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule